// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside the integer datapath of a small processor. In each cycle it receives the two operands, the result and the carry-out of the operation the datapath has just done. It also receives a code naming the class of that operation and a select for the operand width of 8, 16 or 32 bits. From these it works out six status bits: carry, parity, half-carry, zero, sign and signed overflow. It latches them into a flag register on the clock edge, but only while the write enable is high.

The operation class decides which flags change. Additions and subtractions update all six flags. Logic operations update parity, zero and sign, and force carry, half-carry and overflow to 0. Data moves and program-control operations leave the register exactly as it was. Sign, zero and overflow look only at the bits of the selected width. Parity always covers the low result byte.

The block has no sequencing of its own. Its only state is the flag register. A write accepted at a rising edge is visible on the outputs right after that edge.

Top module: `asf_flag_unit`

## Requirements
- R1: An active-low reset clears all six flag outputs to 0.
- R2: While `wr_en` is 0, the flag outputs keep their values, whatever the other inputs do.
- R3: With `wr_en` at 1, operation codes 3 (transfer), 4 (branch) and the unused codes 5 to 7 leave all six flags unchanged.
- R4: For codes 0 (add) and 1 (subtract), `flag_c` takes the value of `alu_carry` (carry of the add, or borrow of the subtract).
- R5: For codes 0, 1 and 2, `flag_p` is 1 when `res[7:0]` holds an even number of one bits (zero ones counts as even) and 0 when the count is odd, at every width.
- R6: For codes 0 and 1, `flag_a` is bit 4 of `opa ^ opb ^ res`, which is the carry or borrow passed from bit 3 into bit 4.
- R7: For codes 0, 1 and 2, `flag_z` is 1 exactly when the result bits inside the selected width are all 0; result bits above that width are ignored.
- R8: For codes 0, 1 and 2, `flag_s` is the top bit of the result at the selected width. Size code 0 gives bit 7, code 1 gives bit 15, and code 2 gives bit 31. Size code 3 acts as code 2.
- R9: For code 0, `flag_o` is 1 when both operand sign bits are equal and the result sign bit differs from them.
- R10: For code 1, `flag_o` is 1 when the operand sign bits differ and the result sign bit differs from that of `opa`.
- R11: For code 2 (logic), `flag_c`, `flag_a` and `flag_o` become 0, and `alu_carry` has no effect.
- R12: Flags written at a rising edge with `wr_en` high appear on the outputs immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Flag register write enable |
| op | input | 3 | Operation class: 0 add, 1 subtract, 2 logic, 3 transfer, 4 branch |
| size_sel | input | 2 | Operand width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| res | input | 32 | Result from the datapath |
| alu_carry | input | 1 | Carry-out or borrow-out at the selected width |
| flag_c | output | 1 | Carry flag |
| flag_p | output | 1 | Parity flag, even parity of the low result byte |
| flag_a | output | 1 | Half-carry flag between bits 3 and 4 |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Signed overflow flag |

## Verification
The bench builds the block with its default parameters: a base lane of 8 bits and three widths, so the data path is 32 bits wide and bit 4 marks the half-carry. With these values, every width has a vector whose result sign bit lies exactly on the lane boundary. Other vectors set result bits above the selected width, to show they are ignored for zero, sign and overflow. A logic vector in the same table shows that a set `alu_carry` has no effect. Transfer and branch vectors, a write-disabled add and a reset in the middle of the run then confirm that the register holds or clears as required.

// File: rtl/asf_pkg.sv
package asf_pkg;

    localparam int BASE_W     = 8;
    localparam int NUM_SIZES  = 3;
    localparam int DATA_W     = BASE_W << (NUM_SIZES - 1);
    localparam int SIZE_SEL_W = $clog2(NUM_SIZES + 1);
    localparam int OP_W       = 3;
    localparam int AUX_BIT    = BASE_W / 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_LOGIC  = 3'd2,
        OP_MOVE   = 3'd3,
        OP_BRANCH = 3'd4
    } op_e;

    typedef struct packed {
        logic c;
        logic p;
        logic a;
        logic z;
        logic s;
        logic o;
    } flags_t;

endpackage

// File: rtl/asf_lane_select.sv
module asf_lane_select
    import asf_pkg::*;
(
    input  logic [SIZE_SEL_W-1:0] size_sel,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic [DATA_W-1:0]     res,
    output logic                  sign_a,
    output logic                  sign_b,
    output logic                  sign_r,
    output logic                  res_zero
);

    logic [NUM_SIZES-1:0] msb_a;
    logic [NUM_SIZES-1:0] msb_b;
    logic [NUM_SIZES-1:0] msb_r;
    logic [NUM_SIZES-1:0] zero_r;
    logic [SIZE_SEL_W-1:0] lane_idx;

    generate
        for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
            localparam int LW = BASE_W << g;
            assign msb_a[g]  = opa[LW-1];
            assign msb_b[g]  = opb[LW-1];
            assign msb_r[g]  = res[LW-1];
            assign zero_r[g] = ~|res[LW-1:0];
        end
    endgenerate

    always_comb begin
        if (size_sel >= SIZE_SEL_W'(NUM_SIZES))
            lane_idx = SIZE_SEL_W'(NUM_SIZES - 1);
        else
            lane_idx = size_sel;
    end

    assign sign_a   = msb_a[lane_idx];
    assign sign_b   = msb_b[lane_idx];
    assign sign_r   = msb_r[lane_idx];
    assign res_zero = zero_r[lane_idx];

endmodule

// File: rtl/asf_parity.sv
module asf_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_in,
    output logic         even
);

    assign even = ~^bits_in;

endmodule

// File: rtl/asf_flag_calc.sv
module asf_flag_calc
    import asf_pkg::*;
(
    input  op_e                   op,
    input  logic [SIZE_SEL_W-1:0] size_sel,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic [DATA_W-1:0]     res,
    input  logic                  alu_carry,
    output flags_t                next_flags,
    output logic                  update
);

    logic sign_a;
    logic sign_b;
    logic sign_r;
    logic res_zero;
    logic par_even;
    logic [DATA_W-1:0] carry_vec;
    logic unused_carry_bits;

    asf_lane_select lane_i (
        .size_sel (size_sel),
        .opa      (opa),
        .opb      (opb),
        .res      (res),
        .sign_a   (sign_a),
        .sign_b   (sign_b),
        .sign_r   (sign_r),
        .res_zero (res_zero)
    );

    asf_parity #(.W(BASE_W)) par_i (
        .bits_in (res[BASE_W-1:0]),
        .even    (par_even)
    );

    assign carry_vec         = opa ^ opb ^ res;
    assign unused_carry_bits = ^carry_vec;

    always_comb begin
        next_flags = '0;
        update     = 1'b0;
        unique case (op)
            OP_ADD: begin
                update       = 1'b1;
                next_flags.c = alu_carry;
                next_flags.p = par_even;
                next_flags.a = carry_vec[AUX_BIT];
                next_flags.z = res_zero;
                next_flags.s = sign_r;
                next_flags.o = (sign_a == sign_b) && (sign_r != sign_a);
            end
            OP_SUB: begin
                update       = 1'b1;
                next_flags.c = alu_carry;
                next_flags.p = par_even;
                next_flags.a = carry_vec[AUX_BIT];
                next_flags.z = res_zero;
                next_flags.s = sign_r;
                next_flags.o = (sign_a != sign_b) && (sign_r != sign_a);
            end
            OP_LOGIC: begin
                update       = 1'b1;
                next_flags.p = par_even;
                next_flags.z = res_zero;
                next_flags.s = sign_r;
            end
            default: begin
                update = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/asf_flag_unit.sv
module asf_flag_unit
    import asf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [OP_W-1:0]       op,
    input  logic [SIZE_SEL_W-1:0] size_sel,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic [DATA_W-1:0]     res,
    input  logic                  alu_carry,
    output logic                  flag_c,
    output logic                  flag_p,
    output logic                  flag_a,
    output logic                  flag_z,
    output logic                  flag_s,
    output logic                  flag_o
);

    flags_t next_flags;
    flags_t flag_q;
    logic   calc_update;

    asf_flag_calc calc_i (
        .op         (op_e'(op)),
        .size_sel   (size_sel),
        .opa        (opa),
        .opb        (opb),
        .res        (res),
        .alu_carry  (alu_carry),
        .next_flags (next_flags),
        .update     (calc_update)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= '0;
        else if (wr_en && calc_update)
            flag_q <= next_flags;
    end

    assign flag_c = flag_q.c;
    assign flag_p = flag_q.p;
    assign flag_a = flag_q.a;
    assign flag_z = flag_q.z;
    assign flag_s = flag_q.s;
    assign flag_o = flag_q.o;

endmodule

// File: rtl/asf_flag_checker.sv
module asf_flag_checker
    import asf_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [OP_W-1:0] op,
    input logic            alu_carry,
    input logic            flag_c,
    input logic            flag_p,
    input logic            flag_a,
    input logic            flag_z,
    input logic            flag_s,
    input logic            flag_o
);

    logic [5:0] flags_now;
    assign flags_now = {flag_c, flag_p, flag_a, flag_z, flag_s, flag_o};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags_now == 6'b0));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags_now));

    // R3
    no_touch_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op >= 3'd3)) |=> $stable(flags_now));

    // R4
    carry_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op <= 3'd1)) |=> (flag_c == $past(alu_carry)));

    // R11
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op == 3'd2)) |=> (!flag_c && !flag_a && !flag_o));

endmodule

bind asf_flag_unit asf_flag_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .op        (op),
    .alu_carry (alu_carry),
    .flag_c    (flag_c),
    .flag_p    (flag_p),
    .flag_a    (flag_a),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_o    (flag_o)
);

// File: tb/asf_flag_unit_tb_top.sv
`timescale 1ns/100ps
module asf_flag_unit_tb_top;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic        cin;
        logic [5:0]  exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 2'd0, 32'h0000000F, 32'h00000001, 32'h00000010, 1'b0, 6'b001000},
        '{3'd0, 2'd0, 32'h0000007F, 32'h00000001, 32'h00000080, 1'b0, 6'b001011},
        '{3'd0, 2'd0, 32'h000000FF, 32'h00000001, 32'h00000100, 1'b1, 6'b111100},
        '{3'd1, 2'd1, 32'h00008000, 32'h00000001, 32'h00007FFF, 1'b0, 6'b011001},
        '{3'd1, 2'd2, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b1, 6'b111010},
        '{3'd1, 2'd1, 32'h00000010, 32'h00000001, 32'h0000000F, 1'b0, 6'b011000},
        '{3'd0, 2'd2, 32'h12345678, 32'h11111111, 32'h23456789, 1'b0, 6'b000000},
        '{3'd2, 2'd2, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000, 1'b1, 6'b010100},
        '{3'd2, 2'd1, 32'h0000FFFF, 32'h00008003, 32'hFFFF8003, 1'b1, 6'b010010},
        '{3'd3, 2'd0, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 6'b010010},
        '{3'd4, 2'd0, 32'h00000080, 32'h00000000, 32'h00000080, 1'b0, 6'b010010},
        '{3'd0, 2'd1, 32'h00008000, 32'h00008000, 32'h00010000, 1'b1, 6'b110101},
        '{3'd0, 2'd3, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0, 6'b010010}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  op;
    logic [1:0]  size_sel;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [31:0] res;
    logic        alu_carry;
    logic        flag_c, flag_p, flag_a, flag_z, flag_s, flag_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    asf_flag_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .op        (op),
        .size_sel  (size_sel),
        .opa       (opa),
        .opb       (opb),
        .res       (res),
        .alu_carry (alu_carry),
        .flag_c    (flag_c),
        .flag_p    (flag_p),
        .flag_a    (flag_a),
        .flag_z    (flag_z),
        .flag_s    (flag_s),
        .flag_o    (flag_o)
    );

    task automatic check_bit(input string tag, input string name,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, name, act, exp);
        end
    endtask

    function automatic string tag_for(input int idx, input logic [2:0] o);
        if (o >= 3'd3) return "R3";
        if (o == 3'd2 && (idx == 5 || idx == 3 || idx == 0)) return "R11";
        case (idx)
            5: return "R4";
            4: return "R5";
            3: return "R6";
            2: return "R7";
            1: return "R8";
            default: return (o == 3'd0) ? "R9" : "R10";
        endcase
    endfunction

    task automatic check_all(input logic [5:0] exp, input logic [2:0] o,
                             input string force_tag);
        logic [5:0] act;
        string names [6];
        act = {flag_c, flag_p, flag_a, flag_z, flag_s, flag_o};
        names = '{"o", "s", "z", "a", "p", "c"};
        for (int i = 0; i < 6; i++) begin
            string t;
            t = (force_tag != "") ? force_tag : tag_for(i, o);
            check_bit(t, names[i], act[i], exp[i]);
        end
    endtask

    task automatic drive(input vec_t v, input logic we);
        op        = v.op;
        size_sel  = v.sz;
        opa       = v.a;
        opb       = v.b;
        res       = v.r;
        alu_carry = v.cin;
        wr_en     = we;
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all(6'b000000, 3'd0, "R1");
        rst_n = 1'b1;

        // R12: each write is visible right after the edge that takes it
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k], 1'b1);
            @(negedge clk);
            check_all(VEC[k].exp, VEC[k].op, "");
        end

        // R2: add with write enable low must not change 010010
        @(negedge clk);
        drive(VEC[1], 1'b0);
        @(negedge clk);
        @(negedge clk);
        check_all(6'b010010, 3'd0, "R2");

        // R3: unused op code 7 with write enable high
        drive('{3'd7, 2'd0, 32'h0, 32'h0, 32'h0, 1'b1, 6'b0}, 1'b1);
        @(negedge clk);
        check_all(6'b010010, 3'd7, "R3");

        // R12: a single write then hold
        drive(VEC[2], 1'b1);
        @(negedge clk);
        check_all(VEC[2].exp, 3'd0, "R12");
        wr_en = 1'b0;

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check_all(6'b000000, 3'd0, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule